// File: doc/BRIEF.md
# Embedded Program/Erase Controller with Status Polling

This block carries out already-decoded write commands against a small on-chip array of 16-bit words, the way an embedded flash controller does. A program command clears bits in one word and can never set them. An erase command returns a region to all ones. The array is split into four sectors: a boot sector, two parameter sectors and a main sector. Their sizes keep the ratio 1:1:1:13 of a real part and are scaled by one parameter.

A boot lockout flag protects the boot sector. A command sets it, and it changes which program and erase operations are allowed and how far an erase reaches. A high-voltage override input suspends the lockout for as long as it is held. Each accepted operation raises `busy` for a number of clock cycles set by a parameter. While `busy` is high, reads return a polling status word instead of array data. An identification mode returns fixed codes and the lockout state.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset `busy` is 0, every array word is FFFFh, lockout is clear and identification mode is off.
- R2: A program (cmd_op=0) to address A stores old(A) AND cmd_data, so bits can only go from 1 to 0.
- R3: A sector erase (cmd_op=1) whose address lies in parameter sector 1 (words UNIT_WORDS..2*UNIT_WORDS-1) or parameter sector 2 (2*UNIT_WORDS..3*UNIT_WORDS-1) sets only that sector to FFFFh.
- R4: A sector erase whose address lies in the main sector (words from 3*UNIT_WORDS up) or in the boot sector (words 0..UNIT_WORDS-1) erases the main sector. It also erases the boot sector when lockout is not in effect.
- R5: A chip erase (cmd_op=2) sets every word to FFFFh, except the boot sector while lockout is in effect.
- R6: With lockout in effect, a program aimed at the boot sector is refused: `busy` stays 0 and the word is unchanged.
- R7: While `lock_ovr` is 1 the lockout is not in effect. It is in effect again as soon as `lock_ovr` returns to 0. The lockout command is cmd_op=3.
- R8: `busy` rises on the clock edge that accepts an operation and stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R9: A read while `busy` returns a status word. Bit 7 is the inverse of bit 7 of the programmed data during a program and 0 during an erase. All bits other than 7 and 6 are 0.
- R10: Bit 6 of the status word is 0 on the first busy read after an operation is accepted and flips on every further busy read. Once `busy` is low, reads return true array data.
- R11: In identification mode (enter cmd_op=4, leave cmd_op=5), reads return 00DAh at address 0, 003Eh at address 1, the stored lockout flag in bit 0 at address 2, and 0 at any other address.
- R12: Any command presented while `busy` is high is ignored.
- R13: `rd_data` takes its new value on the clock edge that samples `rd_en`, and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code: 0 program, 1 sector erase, 2 chip erase, 3 set lockout, 4 enter ID, 5 leave ID |
| cmd_addr | input | AW | Word address for program, or address selecting the sector for sector erase |
| cmd_data | input | 16 | Program data |
| lock_ovr | input | 1 | High-voltage lockout override level |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| rd_data | output | 16 | Read result (array, status or identification) |
| busy | output | 1 | Operation in progress |

## Verification
The hardest case to reach is a read whose result depends on two stored states at once: the lockout flag and whether the override is held when an erase is accepted. The boot sector must first be written under override, the override dropped, and erases then issued at main-sector and boot-sector addresses. Only the surviving boot word tells which extent was used. The stimulus walks this path in order: set lockout, program the boot word under override, then run a locked main erase, a locked chip erase and an overridden boot-address sector erase. Each step is followed by a read-back. Commands issued while `busy` is high are aimed at words and modes whose change would be visible afterwards.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

  localparam int DW = 16;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_SERASE = 3'd1,
    OP_CERASE = 3'd2,
    OP_LOCK   = 3'd3,
    OP_IDON   = 3'd4,
    OP_IDOFF  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SEC_BOOT = 2'd0,
    SEC_PAR1 = 2'd1,
    SEC_PAR2 = 2'd2,
    SEC_MAIN = 2'd3
  } sec_e;

  // sector of a word address; sizes are 1:1:1:13 units of unit_words
  function automatic sec_e sector_of(logic [31:0] addr, logic [31:0] unit_words);
    logic [31:0] u;
    u = addr / unit_words;
    if (u == 32'd0)      return SEC_BOOT;
    else if (u == 32'd1) return SEC_PAR1;
    else if (u == 32'd2) return SEC_PAR2;
    else                 return SEC_MAIN;
  endfunction

  // does an erase reach a word in sector word_sec
  function automatic logic erase_hits(sec_e word_sec, logic chip, sec_e target, logic locked);
    if (word_sec == SEC_BOOT && locked) return 1'b0;
    if (chip) return 1'b1;
    case (target)
      SEC_PAR1: return word_sec == SEC_PAR1;
      SEC_PAR2: return word_sec == SEC_PAR2;
      default:  return (word_sec == SEC_MAIN) || (word_sec == SEC_BOOT);
    endcase
  endfunction

  // polling word returned while busy
  function automatic logic [DW-1:0] status_word(logic is_erase, logic last_b7, logic tog);
    logic [DW-1:0] w;
    w = '0;
    w[7] = is_erase ? 1'b0 : ~last_b7;
    w[6] = tog;
    return w;
  endfunction

  // identification read
  function automatic logic [DW-1:0] id_word(logic [31:0] a, logic [DW-1:0] mfr,
                                            logic [DW-1:0] dev, logic lock);
    if (a == 32'd0)      return mfr;
    else if (a == 32'd1) return dev;
    else if (a == 32'd2) return {{(DW-1){1'b0}}, lock};
    else                 return '0;
  endfunction

endpackage

// File: rtl/nvm_pe_timer.sv
module nvm_pe_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] dur,
  output logic          busy,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= dur - CW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign done = busy && (cnt == '0);

  // R8
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R8
  done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

endmodule

// File: rtl/nvm_pe_rdport.sv
module nvm_pe_rdport
  import nvm_pe_pkg::*;
#(
  parameter int          AW       = 7,
  parameter logic [15:0] MFR_CODE = 16'h00DA,
  parameter logic [15:0] DEV_CODE = 16'h003E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic          start,
  input  logic          op_erase,
  input  logic          last_b7,
  input  logic          id_mode,
  input  logic          lock_state,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] rd_data
);

  logic tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (start)               tog <= 1'b0;
      else if (rd_en && busy)  tog <= ~tog;
      if (rd_en) begin
        if (busy)         rd_data <= status_word(op_erase, last_b7, tog);
        else if (id_mode) rd_data <= id_word(32'(rd_addr), MFR_CODE, DEV_CODE, lock_state);
        else              rd_data <= arr_word;
      end
    end
  end

  // R9
  erase_poll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && op_erase) |=> (rd_data[7] == 1'b0));

  // R9
  prog_poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && !op_erase) |=> (rd_data[7] == ~$past(last_b7)));

  // R10
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));

  // R13
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
  import nvm_pe_pkg::*;
#(
  parameter int          UNIT_WORDS = 8,
  parameter int          PROG_CYC   = 6,
  parameter int          ERASE_CYC  = 12,
  parameter logic [15:0] MFR_CODE   = 16'h00DA,
  parameter logic [15:0] DEV_CODE   = 16'h003E,
  localparam int         WORDS      = 16 * UNIT_WORDS,
  localparam int         AW         = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          lock_ovr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);

  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [DW-1:0] mem [WORDS];
  logic          lock_q, id_q, op_erase_q, last_b7_q;
  logic          lock_eff, take, prog_req, prog_refused, prog_go;
  logic          serase_go, cerase_go, erase_go, start, done;
  logic [CW-1:0] dur;
  logic [DW-1:0] old_word;
  sec_e          tgt;

  // named command events
  assign lock_eff     = lock_q & ~lock_ovr;
  assign tgt          = sector_of(32'(cmd_addr), 32'(UNIT_WORDS));
  assign take         = cmd_valid & ~busy;
  assign prog_req     = take & (cmd_op == OP_PROG);
  assign prog_refused = prog_req & (tgt == SEC_BOOT) & lock_eff;
  assign prog_go      = prog_req & ~prog_refused;
  assign serase_go    = take & (cmd_op == OP_SERASE);
  assign cerase_go    = take & (cmd_op == OP_CERASE);
  assign erase_go     = serase_go | cerase_go;
  assign start        = prog_go | erase_go;
  assign dur          = prog_go ? CW'(PROG_CYC) : CW'(ERASE_CYC);
  assign old_word     = mem[cmd_addr];

  // word array
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (prog_go) begin
      mem[cmd_addr] <= old_word & cmd_data;
    end else if (erase_go) begin
      for (int i = 0; i < WORDS; i++)
        if (erase_hits(sector_of(32'(i), 32'(UNIT_WORDS)), cerase_go, tgt, lock_eff))
          mem[i] <= '1;
    end
  end

  // mode and last-operation state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      id_q       <= 1'b0;
      op_erase_q <= 1'b0;
      last_b7_q  <= 1'b0;
    end else begin
      if (take && cmd_op == OP_LOCK)  lock_q <= 1'b1;
      if (take && cmd_op == OP_IDON)  id_q   <= 1'b1;
      if (take && cmd_op == OP_IDOFF) id_q   <= 1'b0;
      if (start) begin
        op_erase_q <= erase_go;
        last_b7_q  <= cmd_data[7];
      end
    end
  end

  nvm_pe_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .dur   (dur),
    .busy  (busy),
    .done  (done)
  );

  nvm_pe_rdport #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .start      (start),
    .op_erase   (op_erase_q),
    .last_b7    (last_b7_q),
    .id_mode    (id_q),
    .lock_state (lock_q),
    .arr_word   (mem[rd_addr]),
    .rd_data    (rd_data)
  );

  // R2
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> (mem[$past(cmd_addr)] == ($past(old_word) & $past(cmd_data))));

  // R6
  refused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_refused && !busy) |=> (!busy && mem[$past(cmd_addr)] == $past(old_word)));

  // R12
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(lock_q) && $stable(id_q) && $stable(op_erase_q)));

  // R8
  op_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: tb/sim_nvm_pe_ctrl.sv
module sim_nvm_pe_ctrl;

  localparam int UNIT = 8;
  localparam int NW   = 16 * UNIT;
  localparam int AW   = $clog2(NW);
  localparam int PCYC = 6;
  localparam int ECYC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0]   cmd_data = '0;
  logic          lock_ovr = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          pend = 0;

  always #2 clk = ~clk;

  nvm_pe_ctrl #(.UNIT_WORDS(UNIT), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock_ovr(lock_ovr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares one cycle after each read strobe (R13)
  always @(negedge clk) begin
    if (pend) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_data === e, t, int'(rd_data), int'(e));
    end
    pend = rd_en;
  end

  task automatic rd(input int a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1;
    rd_addr = AW'(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input int a, input logic [15:0] d);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = AW'(a);
    cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic busy_len(input int n, input string tag);
    int c;
    c = 0;
    @(negedge clk);
    while (busy) begin
      c++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    chk(c == n, tag, c, n);
  endtask

  function automatic logic [15:0] poll(input bit er, input logic [15:0] d, input bit t);
    logic [15:0] w;
    w = 16'h0000;
    w[7] = er ? 1'b0 : !d[7];
    w[6] = t;
    return w;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    rd(0, 16'hFFFF, "R1 word 0");
    rd(9, 16'hFFFF, "R1 word 9");
    rd(127, 16'hFFFF, "R1 word 127");
    rd(1, 16'hFFFF, "R1 not in ID mode");

    // R8 program duration, R2 and-in
    issue(3'd0, 40, 16'hA5F0);
    busy_len(PCYC, "R8 program busy length");
    rd(40, 16'hA5F0, "R2 program word 40");

    // R9 R10 polling during program
    issue(3'd0, 30, 16'h1234);
    rd(30, poll(0, 16'h1234, 0), "R9 R10 poll read 1");
    rd(30, poll(0, 16'h1234, 1), "R10 poll read 2");
    rd(30, poll(0, 16'h1234, 0), "R10 poll read 3");
    wait_idle();
    rd(30, 16'h1234, "R10 true data after done");
    issue(3'd0, 30, 16'hFF0F);
    wait_idle();
    rd(30, 16'h1204, "R2 bits only cleared");

    // R3 parameter sector erase
    issue(3'd0, 9, 16'h0000); wait_idle();
    issue(3'd0, 17, 16'h00FF); wait_idle();
    issue(3'd1, 10, 16'h0000);
    busy_len(ECYC, "R8 erase busy length");
    rd(9, 16'hFFFF, "R3 par1 erased");
    rd(17, 16'h00FF, "R3 par2 kept");
    rd(40, 16'hA5F0, "R3 main kept");

    // R11 lockout set and identification
    issue(3'd3, 0, 16'h0000);
    chk(busy == 1'b0, "R7 lockout command no busy", busy, 0);
    issue(3'd4, 0, 16'h0000);
    rd(2, 16'h0001, "R11 lock bit");
    rd(0, 16'h00DA, "R11 maker code");
    rd(1, 16'h003E, "R11 device code");
    rd(6, 16'h0000, "R11 other address");
    issue(3'd5, 0, 16'h0000);
    rd(40, 16'hA5F0, "R11 exit to array");

    // R6 locked boot program refused
    issue(3'd0, 3, 16'h0000);
    chk(busy == 1'b0, "R6 refused no busy", busy, 0);
    rd(3, 16'hFFFF, "R6 boot word unchanged");

    // R7 override
    lock_ovr = 1'b1;
    issue(3'd0, 3, 16'h00F0); wait_idle();
    rd(3, 16'h00F0, "R7 override allows boot program");
    lock_ovr = 1'b0;
    issue(3'd0, 4, 16'h0000);
    chk(busy == 1'b0, "R7 lockout back after override", busy, 0);
    rd(4, 16'hFFFF, "R7 boot word 4 unchanged");

    // R4 locked main erase, R9 erase polling
    issue(3'd1, 50, 16'h0000);
    rd(50, poll(1, 16'h0000, 0), "R9 erase poll read 1");
    rd(50, poll(1, 16'h0000, 1), "R10 erase poll read 2");
    wait_idle();
    rd(3, 16'h00F0, "R4 boot kept when locked");
    rd(30, 16'hFFFF, "R4 main erased");
    rd(40, 16'hFFFF, "R4 main erased 40");
    rd(17, 16'h00FF, "R4 par2 untouched");

    // R12 commands while busy ignored
    issue(3'd1, 18, 16'h0000);
    issue(3'd4, 0, 16'h0000);
    issue(3'd0, 60, 16'h0000);
    wait_idle();
    rd(0, 16'hFFFF, "R12 ID entry ignored while busy");
    rd(60, 16'hFFFF, "R12 program ignored while busy");
    rd(17, 16'hFFFF, "R3 par2 erased");

    // R5 locked chip erase
    issue(3'd0, 100, 16'h1111); wait_idle();
    issue(3'd2, 0, 16'h0000); wait_idle();
    rd(3, 16'h00F0, "R5 boot kept by locked chip erase");
    rd(100, 16'h0000 | 16'hFFFF, "R5 main erased by chip erase");

    // R4 R7 boot address sector erase under override
    lock_ovr = 1'b1;
    issue(3'd1, 2, 16'h0000); wait_idle();
    rd(3, 16'hFFFF, "R4 boot erased with main when unlocked");

    // R5 unlocked chip erase, full sweep
    issue(3'd0, 5, 16'h0F0F); wait_idle();
    issue(3'd0, 70, 16'h0000); wait_idle();
    issue(3'd0, 12, 16'h0000); wait_idle();
    issue(3'd2, 0, 16'h0000); wait_idle();
    lock_ovr = 1'b0;
    for (int i = 0; i < NW; i++) rd(i, 16'hFFFF, "R5 unlocked chip erase sweep");

    // R11 stored lockout persists
    issue(3'd4, 0, 16'h0000);
    rd(2, 16'h0001, "R11 lock bit persists");
    issue(3'd5, 0, 16'h0000);

    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R13 all reads answered", exp_q.size(), 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule